// File: doc/BRIEF.md
# SD Host Data Buffer Port

This block is the data staging point of an SD/MMC-style host controller. It sits between a 32-bit register bus and a byte-wide card-side stream and holds one data block at a time in an internal word buffer. The bus sees one 32-bit data register. Writes to it land in a single-entry post-write register and are committed to the buffer one cycle later. Reads from it are served from a prefetch register that is loaded from the buffer ahead of the read. As a result, a write followed by a read of the same register is not a loopback.

Software programs a byte length and a direction and then pulses `start_i`. In the to-card direction, `bwe_o` allows ceil(len/4) word writes. The block then streams len bytes out on the card side and re-arms for the next block. In the from-card direction, the block accepts len bytes from the card, preloads the first word, and raises `bre_o` for ceil(len/4) word reads. Any access made while its ready flag is low sets the sticky `bada_o` error flag. The largest block length is fixed by a parameter.

Top module: `sd_data_buf`

## Requirements
- R1: After reset `bwe_o`, `bre_o`, `bada_o`, `tx_valid_o` and `rx_ready_o` are 0 and `data_rdata_o` is 0.
- R2: After a start with `dir_rd_i`=0, `bwe_o` is 1 until ceil(len/4) writes have been accepted, and is 0 from the cycle after the last one.
- R3: In the to-card direction the card side presents exactly len bytes in order. Byte 0 of the stream is bits [7:0] of the first written word (little-endian within each word). `tx_data_o` holds steady while `tx_valid_o`=1 and `tx_ready_i`=0.
- R4: When the card side has taken the last byte of a block, `tx_valid_o` drops and `bwe_o` returns to 1 for the next block.
- R5: After a start with `dir_rd_i`=1, `rx_ready_o` is 1 until len bytes have been accepted. Within two cycles after that, `bre_o` is 1 and `data_rdata_o` shows the first buffer word.
- R6: Each read accepted while `bre_o`=1 moves `data_rdata_o` to the next word by the next cycle. After ceil(len/4) reads, `bre_o` is 0 and `rx_ready_o` is 1 again. `data_rdata_o` does not change while `bre_o`=1 and no read is made.
- R7: In the last word of a from-card block whose length is not a multiple of 4, the bytes at positions len and above read as zero.
- R8: A read while `bre_o`=0 sets `bada_o` and does not advance the read data.
- R9: A write while `bwe_o`=0 sets `bada_o`, and its data never reaches the card stream.
- R10: `bada_o` stays set until a cycle with `bada_clr_i`=1 and no new bad access. A bad access in the same cycle as a clear leaves it set.
- R11: A length of 0 or a length above `MAX_BLK_BYTES` (default 512) is taken as `MAX_BLK_BYTES`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Pulse: capture length and direction, begin a transfer |
| dir_rd_i | input | 1 | Direction at start: 1 = from card, 0 = to card |
| blk_len_i | input | 11 | Block length in bytes |
| data_we_i | input | 1 | Bus write to the data register |
| data_wdata_i | input | 32 | Bus write data |
| data_re_i | input | 1 | Bus read of the data register |
| data_rdata_o | output | 32 | Bus read data (prefetch register) |
| bada_clr_i | input | 1 | Write-1-to-clear for the bad-access flag |
| bwe_o | output | 1 | Buffer write enable status |
| bre_o | output | 1 | Buffer read enable status |
| bada_o | output | 1 | Sticky bad-access flag |
| tx_valid_o | output | 1 | Card-side outgoing byte valid |
| tx_data_o | output | 8 | Card-side outgoing byte |
| tx_ready_i | input | 1 | Card side takes the outgoing byte |
| rx_valid_i | input | 1 | Card-side incoming byte valid |
| rx_data_i | input | 8 | Card-side incoming byte |
| rx_ready_o | output | 1 | Block accepts the incoming byte |

## Verification
The assertions assume that `start_i` is a single-cycle pulse issued only with a stable length and direction. They also assume that the card side follows valid/ready rules, so an offered byte stays unchanged until it is accepted. The bench drives every input half a cycle away from the rising edge. It changes the card byte only after an acceptance, and it pulses start only between blocks. Bad accesses are issued on purpose and only where the bench then checks both the flag and the data that follows.

// File: rtl/sd_buf_pkg.sv
package sd_buf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WFILL,
    ST_WDRAIN,
    ST_RFILL,
    ST_RLOAD,
    ST_RREAD
  } buf_st_e;
endpackage

// File: rtl/sd_buf_mem.sv
module sd_buf_mem #(
  parameter int DEPTH = 128,
  parameter int AW    = 7
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [31:0]   wdata_i,
  input  logic [3:0]    wstrb_i,
  input  logic [AW-1:0] raddr_i,
  output logic [31:0]   rdata_o
);
  logic [31:0] mem_q [DEPTH];

  for (genvar l = 0; l < 4; l++) begin : g_lane
    always_ff @(posedge clk_i) begin
      if (we_i && wstrb_i[l]) mem_q[waddr_i][l*8 +: 8] <= wdata_i[l*8 +: 8];
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/sd_buf_err.sv
module sd_buf_err (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_i,
  input  logic wr_i,
  input  logic bre_i,
  input  logic bwe_i,
  input  logic clr_i,
  output logic flag_o
);
  logic bad;
  assign bad = (rd_i && !bre_i) || (wr_i && !bwe_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (bad)    flag_o <= 1'b1;  // set beats clear
    else if (clr_i)  flag_o <= 1'b0;
  end

  // R10
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o && !clr_i |=> flag_o);
endmodule

// File: rtl/sd_data_buf.sv
module sd_data_buf
  import sd_buf_pkg::*;
#(
  parameter int MAX_BLK_BYTES = 512
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        dir_rd_i,
  input  logic [10:0] blk_len_i,
  input  logic        data_we_i,
  input  logic [31:0] data_wdata_i,
  input  logic        data_re_i,
  output logic [31:0] data_rdata_o,
  input  logic        bada_clr_i,
  output logic        bwe_o,
  output logic        bre_o,
  output logic        bada_o,
  output logic        tx_valid_o,
  output logic [7:0]  tx_data_o,
  input  logic        tx_ready_i,
  input  logic        rx_valid_i,
  input  logic [7:0]  rx_data_i,
  output logic        rx_ready_o
);
  localparam int LW    = 11;
  localparam int DEPTH = MAX_BLK_BYTES / 4;
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [LW-1:0] MAXL = LW'(MAX_BLK_BYTES);

  buf_st_e       st_q;
  logic [LW-1:0] len_q, nwords, eff_len;
  logic [LW-1:0] wr_cnt_q, cm_cnt_q, byte_q, rd_cnt_q;
  logic [31:0]   pw_q, pf_q, mem_rdata, mem_wdata;
  logic          pw_vld_q, mem_we;
  logic [3:0]    mem_wstrb;
  logic [AW-1:0] mem_waddr, mem_raddr;
  logic          wr_ok, last_byte;

  assign eff_len   = (blk_len_i == '0 || blk_len_i > MAXL) ? MAXL : blk_len_i;
  assign nwords    = LW'((len_q + LW'(3)) >> 2);
  assign last_byte = (byte_q == len_q - LW'(1));

  assign bwe_o      = (st_q == ST_WFILL) && (wr_cnt_q < nwords);
  assign bre_o      = (st_q == ST_RREAD);
  assign tx_valid_o = (st_q == ST_WDRAIN);
  assign rx_ready_o = (st_q == ST_RFILL);
  assign wr_ok      = data_we_i && bwe_o;
  assign data_rdata_o = pf_q;

  // buffer write: committed post-write word, or one card byte (lane 0 clears the word)
  always_comb begin
    mem_we    = 1'b0;
    mem_waddr = AW'(cm_cnt_q);
    mem_wdata = pw_q;
    mem_wstrb = 4'hf;
    if (st_q == ST_WFILL && pw_vld_q) begin
      mem_we = 1'b1;
    end else if (st_q == ST_RFILL && rx_valid_i) begin
      mem_we    = 1'b1;
      mem_waddr = AW'(byte_q >> 2);
      if (byte_q[1:0] == 2'd0) begin
        mem_wdata = {24'd0, rx_data_i};
        mem_wstrb = 4'hf;
      end else begin
        mem_wdata = {4{rx_data_i}};
        mem_wstrb = 4'b0001 << byte_q[1:0];
      end
    end
  end

  always_comb begin
    unique case (st_q)
      ST_WDRAIN: mem_raddr = AW'(byte_q >> 2);
      ST_RREAD:  mem_raddr = AW'(rd_cnt_q + LW'(1));
      default:   mem_raddr = '0;
    endcase
  end

  assign tx_data_o = mem_rdata[{byte_q[1:0], 3'b000} +: 8];

  sd_buf_mem #(.DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk_i   (clk_i),
    .we_i    (mem_we),
    .waddr_i (mem_waddr),
    .wdata_i (mem_wdata),
    .wstrb_i (mem_wstrb),
    .raddr_i (mem_raddr),
    .rdata_o (mem_rdata)
  );

  sd_buf_err u_err (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rd_i   (data_re_i),
    .wr_i   (data_we_i),
    .bre_i  (bre_o),
    .bwe_i  (bwe_o),
    .clr_i  (bada_clr_i),
    .flag_o (bada_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      len_q    <= '0;
      wr_cnt_q <= '0;
      cm_cnt_q <= '0;
      byte_q   <= '0;
      rd_cnt_q <= '0;
      pw_q     <= '0;
      pw_vld_q <= 1'b0;
      pf_q     <= '0;
    end else if (start_i) begin
      st_q     <= dir_rd_i ? ST_RFILL : ST_WFILL;
      len_q    <= eff_len;
      wr_cnt_q <= '0;
      cm_cnt_q <= '0;
      byte_q   <= '0;
      rd_cnt_q <= '0;
      pw_vld_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_WFILL: begin
          pw_vld_q <= wr_ok;
          if (wr_ok) begin
            pw_q     <= data_wdata_i;
            wr_cnt_q <= wr_cnt_q + LW'(1);
          end
          if (pw_vld_q) cm_cnt_q <= cm_cnt_q + LW'(1);
          else if (cm_cnt_q == nwords) begin
            st_q   <= ST_WDRAIN;
            byte_q <= '0;
          end
        end
        ST_WDRAIN: if (tx_ready_i) begin
          if (last_byte) begin
            st_q     <= ST_WFILL;
            byte_q   <= '0;
            wr_cnt_q <= '0;
            cm_cnt_q <= '0;
          end else byte_q <= byte_q + LW'(1);
        end
        ST_RFILL: if (rx_valid_i) begin
          if (last_byte) begin
            st_q   <= ST_RLOAD;
            byte_q <= '0;
          end else byte_q <= byte_q + LW'(1);
        end
        ST_RLOAD: begin
          pf_q     <= mem_rdata;
          rd_cnt_q <= '0;
          st_q     <= ST_RREAD;
        end
        ST_RREAD: if (data_re_i) begin
          pf_q <= mem_rdata;
          if (rd_cnt_q == nwords - LW'(1)) begin
            st_q     <= ST_RFILL;
            rd_cnt_q <= '0;
          end else rd_cnt_q <= rd_cnt_q + LW'(1);
        end
        default: ;
      endcase
    end
  end

  // R2
  wr_cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cnt_q <= nwords);
  // R3
  tx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i && !start_i |=> tx_valid_o && $stable(tx_data_o));
  // R6
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bre_o && !data_re_i && !start_i |=> bre_o && $stable(data_rdata_o));
  // R5
  flag_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({bwe_o, bre_o, rx_ready_o, tx_valid_o}));
  // R11
  len_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q != ST_IDLE |-> (len_q != '0 && len_q <= MAXL));
endmodule

// File: tb/sim_sd_data_buf.sv
`timescale 1ns/1ps
module sim_sd_data_buf;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic start_i = 0, dir_rd_i = 0, data_we_i = 0, data_re_i = 0, bada_clr_i = 0;
  logic tx_ready_i = 0, rx_valid_i = 0;
  logic [10:0] blk_len_i = '0;
  logic [31:0] data_wdata_i = '0, data_rdata_o;
  logic [7:0]  rx_data_i = '0, tx_data_o;
  logic bwe_o, bre_o, bada_o, tx_valid_o, rx_ready_o;
  int checks = 0, failures = 0;

  always #2.5 clk_i = ~clk_i;

  sd_data_buf u0 (.*);

  // {dir_rd, len[10:0], seed[7:0]}
  localparam logic [19:0] VEC [10] = '{
    {1'b0, 11'd8,  8'h11}, {1'b0, 11'd5,  8'h22}, {1'b0, 11'd1,  8'h33},
    {1'b0, 11'd64, 8'h45}, {1'b1, 11'd12, 8'h51}, {1'b1, 11'd7,  8'h62},
    {1'b1, 11'd1,  8'h73}, {1'b1, 11'd6,  8'h84}, {1'b0, 11'd3,  8'h97},
    {1'b1, 11'd40, 8'ha9}
  };

  function automatic logic [7:0] pat(input logic [7:0] s, input int k);
    return 8'(s + k * 29 + (k >> 4));
  endfunction
  function automatic int eff(input int len);
    return (len == 0 || len > 512) ? 512 : len;
  endfunction
  function automatic logic [31:0] word(input logic [7:0] s, input int len, input int i);
    logic [31:0] w = '0;
    for (int b = 0; b < 4; b++)
      if (4 * i + b < len) w[b*8 +: 8] = pat(s, 4 * i + b);
    return w;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_start(input bit dir, input int len);
    start_i = 1; dir_rd_i = dir; blk_len_i = 11'(len);
    @(negedge clk_i);
    start_i = 0;
  endtask

  task automatic clear_bada();
    bada_clr_i = 1; @(negedge clk_i); bada_clr_i = 0;
  endtask

  task automatic wr_block(input int len, input logic [7:0] s, input bit stall, input bit extra);
    int n = (eff(len) + 3) / 4, i = 0, k = 0, guard = 0;
    do_start(1'b0, len);
    while (i < n && guard < 5000) begin
      if (bwe_o) begin data_we_i = 1; data_wdata_i = word(s, eff(len), i); i++; end
      else data_we_i = 0;
      @(negedge clk_i); guard++;
    end
    data_we_i = 0;
    check(bwe_o == 1'b0, "R2", 32'(bwe_o), 32'd0);
    if (extra) begin
      data_we_i = 1; data_wdata_i = 32'hdeadbeef;
      @(negedge clk_i);
      data_we_i = 0;
      check(bada_o == 1'b1, "R9", 32'(bada_o), 32'd1);
    end
    guard = 0;
    while (k < eff(len) && guard < 20000) begin
      tx_ready_i = stall ? (guard % 3 != 1) : 1'b1;
      if (tx_valid_o && tx_ready_i) begin
        check(tx_data_o == pat(s, k), extra ? "R9" : "R3", 32'(tx_data_o), 32'(pat(s, k)));
        k++;
      end
      @(negedge clk_i); guard++;
    end
    tx_ready_i = 0;
    check(k == eff(len), "R3", 32'(k), 32'(eff(len)));
    check(tx_valid_o == 0 && bwe_o == 1, "R4", {30'd0, tx_valid_o, bwe_o}, 32'd1);
  endtask

  task automatic rd_block(input int len, input logic [7:0] s, input bit bad);
    int n = (eff(len) + 3) / 4, k = 0, guard = 0;
    bit rdy;
    do_start(1'b1, len);
    if (bad) begin
      data_re_i = 1; @(negedge clk_i); data_re_i = 0;
      check(bada_o == 1'b1, "R8", 32'(bada_o), 32'd1);
    end
    while (k < eff(len) && guard < 20000) begin
      rdy = rx_ready_o;
      rx_valid_i = 1; rx_data_i = pat(s, k);
      @(negedge clk_i); guard++;
      if (rdy) k++;
    end
    rx_valid_i = 0;
    check(rx_ready_o == 0, "R5", 32'(rx_ready_o), 32'd0);
    @(negedge clk_i);
    check(bre_o == 1, "R5", 32'(bre_o), 32'd1);
    for (int i = 0; i < n; i++) begin
      check(data_rdata_o == word(s, eff(len), i),
            (i == n - 1 && eff(len) % 4 != 0) ? "R7" : (bad ? "R8" : "R6"),
            data_rdata_o, word(s, eff(len), i));
      data_re_i = 1; @(negedge clk_i);
    end
    data_re_i = 0;
    check(bre_o == 0 && rx_ready_o == 1, "R6", {30'd0, bre_o, rx_ready_o}, 32'd1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1
    check({bwe_o, bre_o, bada_o, tx_valid_o, rx_ready_o} == 5'd0, "R1",
          {27'd0, bwe_o, bre_o, bada_o, tx_valid_o, rx_ready_o}, 32'd0);
    check(data_rdata_o == 32'd0, "R1", data_rdata_o, 32'd0);
    // R8 idle bad read
    data_re_i = 1; @(negedge clk_i); data_re_i = 0;
    check(bada_o == 1, "R8", 32'(bada_o), 32'd1);
    repeat (3) @(negedge clk_i);
    check(bada_o == 1, "R10", 32'(bada_o), 32'd1);
    // R10 bad write with clear: set wins
    data_we_i = 1; bada_clr_i = 1; @(negedge clk_i); data_we_i = 0; bada_clr_i = 0;
    check(bada_o == 1, "R10", 32'(bada_o), 32'd1);
    clear_bada();
    check(bada_o == 0, "R10", 32'(bada_o), 32'd0);

    foreach (VEC[v]) begin
      if (VEC[v][19]) rd_block(int'(VEC[v][18:8]), VEC[v][7:0], 1'b0);
      else            wr_block(int'(VEC[v][18:8]), VEC[v][7:0], VEC[v][0], 1'b0);
    end
    check(bada_o == 0, "R10", 32'(bada_o), 32'd0);

    wr_block(10, 8'h3c, 1'b1, 1'b1);  // R9
    clear_bada();
    rd_block(6, 8'h5a, 1'b1);         // R8
    clear_bada();
    wr_block(0, 8'h01, 1'b0, 1'b0);   // R11
    rd_block(2000, 8'h02, 1'b0);      // R11

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule